// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block runs the two sleep depths of a small 8-bit controller core. The instruction decoder sends it one-cycle strobes when it executes the halt opcode (7F hex) or the stop opcode (6F hex). Software places a NOP (FF hex) in front of either one so that the pipeline is empty on entry. The controller then gates the core clock, and it also controls the crystal oscillator enable. It decides when the core may run again.

Halt is the light state. The oscillator keeps running, and the timer and the four external interrupt inputs stay live. Any enabled interrupt request ends the halt. The core then continues at the instruction after the halt, once the interrupt has been serviced. Stop is the deep state. The oscillator is switched off and only a low level on the recovery pin brings the part back. The pin is read as a level, not as an edge, so it also works when that pin is driven as an output. On recovery the core is held in reset until the oscillator reports ready. It then restarts at the fixed stop-recovery entry (address 00C hex, which the core supplies when `vec_sel_o` is set). The port mode registers keep their contents through this restart, so outputs that were driven before the stop do not glitch. Only a true power-on reset clears them.

Top module: `lp_sleep_ctrl`

## Requirements
- R1: While rst_ni is low and up to the first clock edge after its release, cpu_clk_en_o=1, osc_en_o=1, core_rst_o=0, wake_o=0, vec_sel_o=0 and port_mode_rst_o=1. From that edge onward port_mode_rst_o=0.
- R2: A halt strobe taken while running with all irq_req_i bits low sets cpu_clk_en_o=0 from the next cycle on, and osc_en_o stays 1.
- R3: While halted, any irq_req_i bit high at a clock edge sets cpu_clk_en_o=1 after that edge. wake_o is high for exactly that one cycle, with vec_sel_o=0.
- R4: A halt strobe taken while any irq_req_i bit is high never lowers cpu_clk_en_o. wake_o pulses for one cycle after that edge, with vec_sel_o=0.
- R5: A stop strobe taken while running sets cpu_clk_en_o=0 and osc_en_o=0 from the next cycle on. When both strobes arrive in the same cycle, stop wins.
- R6: While stopped, a low level on stop_rec_ni leaves the stopped state SYNC_STAGES+1 edges after it is first sampled. The block then shows osc_en_o=1, core_rst_o=1 and cpu_clk_en_o=0. A pin that is already low when the stop is entered also counts, and a low pin while running has no effect.
- R7: While waiting for the oscillator, cpu_clk_en_o stays 0 and core_rst_o stays 1 until osc_ready_i is high at an edge. After that edge cpu_clk_en_o=1, core_rst_o=0, and wake_o and vec_sel_o are both 1 for one cycle.
- R8: port_mode_rst_o stays 0 through stop entry, recovery and restart.
- R9: While halted or stopped, further strobes have no effect, and while stopped, interrupt requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running control clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| halt_cmd_i | input | 1 | One-cycle halt strobe from the decoder |
| stop_cmd_i | input | 1 | One-cycle stop strobe from the decoder |
| irq_req_i | input | NUM_IRQ | Enabled interrupt requests |
| stop_rec_ni | input | 1 | Stop recovery pin, active low level |
| osc_ready_i | input | 1 | Oscillator stable |
| cpu_clk_en_o | output | 1 | Core clock gate enable |
| osc_en_o | output | 1 | Crystal oscillator enable |
| core_rst_o | output | 1 | Core held in reset during stop recovery |
| wake_o | output | 1 | One-cycle pulse on return to run |
| vec_sel_o | output | 1 | With wake_o: 1 = stop-recovery entry, 0 = resume |
| port_mode_rst_o | output | 1 | Port mode registers may be reset to defaults |

## Verification
The case that is hardest to reach from the ports is a recovery pin that is already low when the stop strobe arrives. The level has to travel through the synchronizer while the controller is still running, and it must be picked up only after the state changes. The bench holds the pin low across the stop strobe to produce this. It also holds the oscillator-ready input low for several cycles after recovery, so that the reset window becomes visible. A cycle-level reference model is compared on every clock, which also covers the case of both strobes arriving together and the strobes and interrupts that arrive while asleep.

// File: rtl/lp_sleep_pkg.sv
package lp_sleep_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STOP = 2'd2,
    ST_OSCW = 2'd3
  } sleep_st_e;
endpackage

// File: rtl/lp_pin_sync.sv
module lp_pin_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_sync
      logic q [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
          always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) q[0] <= RST_VAL;
            else         q[0] <= d_i;
        end else begin : g_next
          always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) q[i] <= RST_VAL;
            else         q[i] <= q[i-1];
        end
      end
      assign q_o = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lp_irq_any.sv
module lp_irq_any #(
  parameter int unsigned NUM_IRQ = 4
) (
  input  logic [NUM_IRQ-1:0] irq_req_i,
  output logic               irq_any_o
);
  assign irq_any_o = |irq_req_i;
endmodule

// File: rtl/lp_sleep_fsm.sv
module lp_sleep_fsm
  import lp_sleep_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      halt_cmd_i,
  input  logic      stop_cmd_i,
  input  logic      irq_any_i,
  input  logic      rec_lvl_ni,
  input  logic      osc_ready_i,
  output sleep_st_e state_o,
  output logic      wake_o,
  output logic      vec_sel_o
);
  sleep_st_e st_q, st_d;
  logic      wake_d, vsel_d;

  always_comb begin
    st_d   = st_q;
    wake_d = 1'b0;
    vsel_d = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (stop_cmd_i)      st_d = ST_STOP;   // stop wins
        else if (halt_cmd_i) begin
          if (irq_any_i) wake_d = 1'b1;        // pass-through, clock never gated
          else           st_d   = ST_HALT;
        end
      end
      ST_HALT: if (irq_any_i) begin
        st_d   = ST_RUN;
        wake_d = 1'b1;
      end
      ST_STOP: if (!rec_lvl_ni) st_d = ST_OSCW;
      ST_OSCW: if (osc_ready_i) begin
        st_d   = ST_RUN;
        wake_d = 1'b1;
        vsel_d = 1'b1;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_RUN;
      wake_o    <= 1'b0;
      vec_sel_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      wake_o    <= wake_d;
      vec_sel_o <= vsel_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/lp_sleep_ctrl.sv
module lp_sleep_ctrl
  import lp_sleep_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               halt_cmd_i,
  input  logic               stop_cmd_i,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic               stop_rec_ni,
  input  logic               osc_ready_i,
  output logic               cpu_clk_en_o,
  output logic               osc_en_o,
  output logic               core_rst_o,
  output logic               wake_o,
  output logic               vec_sel_o,
  output logic               port_mode_rst_o
);
  logic      irq_any, rec_lvl_n, por_q;
  sleep_st_e state;

  lp_irq_any #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .irq_req_i (irq_req_i),
    .irq_any_o (irq_any)
  );

  lp_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rec_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (stop_rec_ni),
    .q_o    (rec_lvl_n)
  );

  lp_sleep_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_cmd_i  (halt_cmd_i),
    .stop_cmd_i  (stop_cmd_i),
    .irq_any_i   (irq_any),
    .rec_lvl_ni  (rec_lvl_n),
    .osc_ready_i (osc_ready_i),
    .state_o     (state),
    .wake_o      (wake_o),
    .vec_sel_o   (vec_sel_o)
  );

  // only power-on reset may default the port mode registers
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) por_q <= 1'b1;
    else         por_q <= 1'b0;

  assign cpu_clk_en_o    = (state == ST_RUN);
  assign osc_en_o        = (state != ST_STOP);
  assign core_rst_o      = (state == ST_OSCW);
  assign port_mode_rst_o = por_q;
endmodule

// File: rtl/lp_sleep_ctrl_chk.sv
module lp_sleep_ctrl_chk #(
  parameter int unsigned NUM_IRQ = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               halt_cmd_i,
  input logic               stop_cmd_i,
  input logic [NUM_IRQ-1:0] irq_req_i,
  input logic               osc_ready_i,
  input logic               cpu_clk_en_o,
  input logic               osc_en_o,
  input logic               core_rst_o,
  input logic               wake_o,
  input logic               vec_sel_o,
  input logic               port_mode_rst_o
);
  assert_halt_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && halt_cmd_i && !stop_cmd_i && irq_req_i == '0) |=> (!cpu_clk_en_o && osc_en_o));

  assert_wake_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  assert_halt_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && halt_cmd_i && !stop_cmd_i && irq_req_i != '0) |=> (cpu_clk_en_o && wake_o && !vec_sel_o));

  assert_stop_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && stop_cmd_i) |=> (!cpu_clk_en_o && !osc_en_o));

  assert_osc_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !cpu_clk_en_o);

  assert_rst_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> (!cpu_clk_en_o && osc_en_o));

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_o && osc_ready_i) |=> (cpu_clk_en_o && wake_o && vec_sel_o));

  assert_vec_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_sel_o |-> wake_o);

  assert_port_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_o || !osc_en_o) |-> !port_mode_rst_o);
endmodule

bind lp_sleep_ctrl lp_sleep_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (.*);

// File: tb/lp_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module lp_sleep_ctrl_tb_top;
  localparam int NUM_IRQ = 4;
  localparam int SYNC    = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic halt_cmd = 1'b0, stop_cmd = 1'b0, pin_n = 1'b1, osc_rdy = 1'b0;
  logic [NUM_IRQ-1:0] irq = '0;
  logic clk_en, osc_en, core_rst, wake, vsel, port_rst;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lp_sleep_ctrl #(.NUM_IRQ(NUM_IRQ), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .halt_cmd_i(halt_cmd), .stop_cmd_i(stop_cmd),
    .irq_req_i(irq), .stop_rec_ni(pin_n), .osc_ready_i(osc_rdy),
    .cpu_clk_en_o(clk_en), .osc_en_o(osc_en), .core_rst_o(core_rst),
    .wake_o(wake), .vec_sel_o(vsel), .port_mode_rst_o(port_rst)
  );

  // reference model: 0 run, 1 halt, 2 stop, 3 oscillator wait
  int m_mode = 0;
  bit m_wake = 0, m_vsel = 0, m_por = 1;
  bit m_sq[$];

  task automatic model_step();
    bit pin_s;
    bit nw, nv;
    int nm;
    pin_s = m_sq[SYNC-1];
    nm = m_mode; nw = 0; nv = 0;
    case (m_mode)
      0: if (stop_cmd) nm = 2;
         else if (halt_cmd) begin
           if (irq != 0) nw = 1; else nm = 1;
         end
      1: if (irq != 0) begin nm = 0; nw = 1; end
      2: if (!pin_s) nm = 3;
      default: if (osc_rdy) begin nm = 0; nw = 1; nv = 1; end
    endcase
    m_sq.push_front(pin_n);
    void'(m_sq.pop_back());
    m_mode = nm; m_wake = nw; m_vsel = nv; m_por = 0;
  endtask

  task automatic compare(string tag);
    logic [5:0] exp, act;
    exp = {m_mode == 0, m_mode != 2, m_mode == 3, m_wake, m_vsel, m_por};
    act = {clk_en, osc_en, core_rst, wake, vsel, port_rst};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {clk_en,osc_en,core_rst,wake,vec_sel,port_rst} actual %b expected %b at %0t",
               tag, act, exp, $time);
    end
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    for (int i = 0; i < SYNC; i++) m_sq.push_back(1'b1);
    repeat (3) @(posedge clk);
    #2;
    compare("R1 reset");
    rst_ni = 1'b1;
    tick("R1 first edge");
    ticks(2, "R1 idle");

    // R6: low pin while running has no effect
    pin_n = 1'b0; ticks(4, "R6 pin low in run"); pin_n = 1'b1; ticks(3, "R6 pin restore");

    // R2/R3: halt, then wake by irq bit 2
    halt_cmd = 1'b1; tick("R2 halt entry"); halt_cmd = 1'b0;
    ticks(3, "R2 halted");
    stop_cmd = 1'b1; tick("R9 stop while halted"); stop_cmd = 1'b0;
    ticks(2, "R9 halted");
    irq = 4'b0100; tick("R3 irq wake"); irq = '0;
    ticks(2, "R3 after wake");

    // R4: halt with pending irq
    irq = 4'b0001; halt_cmd = 1'b1; tick("R4 pass through"); halt_cmd = 1'b0; irq = '0;
    ticks(2, "R4 after");

    // R5: both strobes, stop wins; R9 irq during stop ignored
    halt_cmd = 1'b1; stop_cmd = 1'b1; tick("R5 stop wins"); halt_cmd = 1'b0; stop_cmd = 1'b0;
    irq = 4'b1111; ticks(3, "R9 irq in stop"); irq = '0;
    halt_cmd = 1'b1; tick("R9 halt in stop"); halt_cmd = 1'b0;
    ticks(2, "R5 stopped");

    // R6/R7/R8: recovery with slow oscillator
    pin_n = 1'b0; ticks(SYNC + 2, "R6 recovery");
    pin_n = 1'b1; ticks(4, "R7 osc wait");
    osc_rdy = 1'b1; tick("R7 release"); osc_rdy = 1'b0;
    ticks(3, "R8 after restart");

    // R6: pin already low when stop arrives
    pin_n = 1'b0; ticks(3, "R6 pre-low");
    stop_cmd = 1'b1; tick("R6 stop pre-low"); stop_cmd = 1'b0;
    ticks(2, "R6 pre-low recover");
    pin_n = 1'b1;
    osc_rdy = 1'b1; tick("R7 fast release"); osc_rdy = 1'b0;
    ticks(3, "R8 final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule